// File: doc/BRIEF.md
# ADC Offset and Gain Correction Datapath

This block sits behind an analog-to-digital converter and corrects each raw conversion word before it is stored. A raw 16-bit result, MSB-justified with 12 significant bits, arrives with a valid strobe and a two-bit source select. The block adds an offset coefficient, scales the sum by a gain coefficient, rounds, saturates and hands the corrected 16-bit word out with its own valid strobe exactly three clock cycles later. A new sample may be accepted every cycle.

There are four offset words and two gain codes. The two converters each have an offset of their own. Each converter also has a separate offset for samples taken through the supply-sensor path. Each converter has one gain code. The coefficients arrive on static input buses and are sampled with each sample, so a change to them affects only the samples accepted after it. When the calibration enable is low, the raw word passes through untouched with the same latency.

Top module: `adc_corr_top`

## Requirements
- R1: While rst_ni is low, out_valid_o and out_data_o are both 0.
- R2: A sample accepted with in_valid_i high at a rising edge yields out_valid_o high after the third rising edge, counting the accepting edge. Cycles without a sample yield no output. Back-to-back samples give back-to-back results in order.
- R3: A sample accepted with cal_en_i low comes out equal to in_data_i, bit for bit.
- R4: The offset word holds a 12-bit two's complement count in bits 15:4. It is added to the raw word as count×16. Bits 3:0 of the offset word have no effect on the result.
- R5: In the gain code, bit 6 = 1 gives a factor of (1000+m)/1000 and bit 6 = 0 gives (1000−m)/1000, where m is bits 5:0 (0 to 63).
- R6: With calibration on, the result is (raw + offset×16) × factor, rounded to the nearest integer with halves rounded up.
- R7: A corrected value above 65535 gives FFFFh.
- R8: A corrected value of zero or below gives 0000h.
- R9: in_sel_i picks the coefficients. 0 uses the converter-A offset and gain A. 1 uses the converter-B offset and gain B. 2 uses the converter-A supply offset and gain A. 3 uses the converter-B supply offset and gain B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_en_i | input | 1 | Apply correction; low passes the raw word through |
| in_valid_i | input | 1 | Sample present this cycle |
| in_sel_i | input | 2 | Coefficient set select (R9) |
| in_data_i | input | 16 | Raw MSB-justified conversion word |
| off_adc_a_i | input | 16 | Converter-A offset word |
| off_adc_b_i | input | 16 | Converter-B offset word |
| off_sup_a_i | input | 16 | Supply-path offset word, converter A |
| off_sup_b_i | input | 16 | Supply-path offset word, converter B |
| gain_a_i | input | 7 | Gain code, converter A |
| gain_b_i | input | 7 | Gain code, converter B |
| out_valid_o | output | 1 | Corrected word present |
| out_data_o | output | 16 | Corrected word |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 12-bit coefficient, a 6-bit gain magnitude and a divisor of 1000. With these values, full-scale inputs combined with the largest positive offset and gain drive the product past 65535, so the upper clamp can be reached. Small inputs with a negative offset reach the lower clamp. Words with an exact half in the quotient exercise the rounding rule. A long randomised back-to-back run then changes the coefficients while samples are in flight, covering the reciprocal divide across its whole operand range.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  typedef enum logic [1:0] {
    SRC_ADC_A = 2'd0,
    SRC_ADC_B = 2'd1,
    SRC_SUP_A = 2'd2,
    SRC_SUP_B = 2'd3
  } corr_src_e;

  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned NUM_GAIN = 2;
endpackage

// File: rtl/adc_corr_coef_sel.sv
module adc_corr_coef_sel
  import adc_corr_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned GAIN_MAG_W = 6,
  parameter int unsigned GAIN_DEN   = 1000,
  localparam int unsigned GAIN_W    = GAIN_MAG_W + 1,
  localparam int unsigned FACT_W    = $clog2(GAIN_DEN + (1 << GAIN_MAG_W))
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] off_word_i [NUM_SRC],
  input  logic [GAIN_W-1:0] gain_code_i [NUM_GAIN],
  output logic [DATA_W-1:0] off_word_o,
  output logic [FACT_W-1:0] factor_o
);
  logic [FACT_W-1:0] fact [NUM_GAIN];

  // sign bit set means a positive correction
  for (genvar g = 0; g < NUM_GAIN; g++) begin : g_gain
    logic [FACT_W-1:0] mag;
    assign mag = FACT_W'(gain_code_i[g][GAIN_MAG_W-1:0]);
    assign fact[g] = gain_code_i[g][GAIN_W-1] ? FACT_W'(GAIN_DEN) + mag
                                              : FACT_W'(GAIN_DEN) - mag;
  end

  assign off_word_o = off_word_i[sel_i];
  assign factor_o   = fact[sel_i[0]];
endmodule

// File: rtl/adc_corr_offset_stg.sv
module adc_corr_offset_stg #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned COEF_W  = 12,
  parameter int unsigned FACT_W  = 11,
  localparam int unsigned SUM_W  = DATA_W + 2,
  localparam int unsigned LSB_W  = DATA_W - COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              cal_en_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [DATA_W-1:0] off_word_i,
  input  logic [FACT_W-1:0] factor_i,
  output logic              valid_o,
  output logic              byp_o,
  output logic [DATA_W-1:0] raw_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic [FACT_W-1:0] factor_o
);
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] off_scaled;

  // sign-extend, then drop the unreferenced low bits
  assign off_ext    = {{(SUM_W-DATA_W){off_word_i[DATA_W-1]}}, off_word_i};
  assign off_scaled = off_ext & ~SUM_W'((1 << LSB_W) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      byp_o    <= 1'b0;
      raw_o    <= '0;
      sum_o    <= '0;
      factor_o <= '0;
    end else begin
      valid_o  <= valid_i;
      byp_o    <= ~cal_en_i;
      raw_o    <= raw_i;
      sum_o    <= {{(SUM_W-DATA_W){1'b0}}, raw_i} + off_scaled;
      factor_o <= factor_i;
    end
  end
endmodule

// File: rtl/adc_corr_gain_stg.sv
module adc_corr_gain_stg #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FACT_W  = 11,
  localparam int unsigned SUM_W  = DATA_W + 2,
  localparam int unsigned PROD_W = SUM_W - 1 + FACT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              byp_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [SUM_W-1:0]  sum_i,
  input  logic [FACT_W-1:0] factor_i,
  output logic              valid_o,
  output logic              byp_o,
  output logic [DATA_W-1:0] raw_o,
  output logic [PROD_W-1:0] prod_o
);
  logic              pos;
  logic [PROD_W-1:0] prod_d;

  // non-positive sums clamp to zero here, so only magnitudes are multiplied
  assign pos    = ~sum_i[SUM_W-1] & (|sum_i[SUM_W-2:0]);
  assign prod_d = pos ? PROD_W'(sum_i[SUM_W-2:0]) * PROD_W'(factor_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      byp_o   <= 1'b0;
      raw_o   <= '0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      byp_o   <= byp_i;
      raw_o   <= raw_i;
      prod_o  <= prod_d;
    end
  end

  AST_CLAMP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !byp_i && sum_i[SUM_W-1]) |=> (prod_o == '0)); // R8
endmodule

// File: rtl/adc_corr_norm_stg.sv
module adc_corr_norm_stg #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PROD_W   = 28,
  parameter int unsigned GAIN_DEN = 1000,
  localparam int unsigned NUM_W   = PROD_W + 1,
  localparam int unsigned SHIFT   = NUM_W + $clog2(GAIN_DEN),
  localparam int unsigned RECIP_W = NUM_W + 1,
  localparam int unsigned MUL_W   = NUM_W + RECIP_W,
  localparam int unsigned Q_W     = MUL_W - SHIFT,
  localparam logic [63:0] RECIP   = ((64'd1 << SHIFT) + 64'(GAIN_DEN) - 64'd1) / 64'(GAIN_DEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              byp_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [NUM_W-1:0] num;
  logic [MUL_W-1:0] wide;
  logic [Q_W-1:0]   quot;
  logic             over;
  logic [DATA_W-1:0] data_d;

  // exact round-half-up divide: ceil reciprocal with SHIFT >= NUM_W + log2(DEN)
  assign num    = NUM_W'(prod_i) + NUM_W'(GAIN_DEN / 2);
  assign wide   = MUL_W'(num) * MUL_W'(RECIP[RECIP_W-1:0]);
  assign quot   = Q_W'(wide >> SHIFT);
  assign over   = quot > Q_W'({DATA_W{1'b1}});
  assign data_d = byp_i ? raw_i : (over ? {DATA_W{1'b1}} : quot[DATA_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      data_o  <= data_d;
    end
  end

  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !byp_i && (prod_i >= PROD_W'(65536 * GAIN_DEN)))
    |=> (data_o == {DATA_W{1'b1}})); // R7
endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top
  import adc_corr_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned COEF_W     = 12,
  parameter int unsigned GAIN_MAG_W = 6,
  parameter int unsigned GAIN_DEN   = 1000,
  localparam int unsigned GAIN_W    = GAIN_MAG_W + 1,
  localparam int unsigned FACT_W    = $clog2(GAIN_DEN + (1 << GAIN_MAG_W)),
  localparam int unsigned SUM_W     = DATA_W + 2,
  localparam int unsigned PROD_W    = SUM_W - 1 + FACT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_en_i,
  input  logic              in_valid_i,
  input  logic [1:0]        in_sel_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [DATA_W-1:0] off_adc_a_i,
  input  logic [DATA_W-1:0] off_adc_b_i,
  input  logic [DATA_W-1:0] off_sup_a_i,
  input  logic [DATA_W-1:0] off_sup_b_i,
  input  logic [GAIN_W-1:0] gain_a_i,
  input  logic [GAIN_W-1:0] gain_b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic [DATA_W-1:0] off_words [NUM_SRC];
  logic [GAIN_W-1:0] gain_codes [NUM_GAIN];
  logic [DATA_W-1:0] off_sel;
  logic [FACT_W-1:0] fact_sel;

  assign off_words[SRC_ADC_A] = off_adc_a_i;
  assign off_words[SRC_ADC_B] = off_adc_b_i;
  assign off_words[SRC_SUP_A] = off_sup_a_i;
  assign off_words[SRC_SUP_B] = off_sup_b_i;
  assign gain_codes[0]        = gain_a_i;
  assign gain_codes[1]        = gain_b_i;

  logic              s1_valid, s1_byp;
  logic [DATA_W-1:0] s1_raw;
  logic [SUM_W-1:0]  s1_sum;
  logic [FACT_W-1:0] s1_fact;
  logic              s2_valid, s2_byp;
  logic [DATA_W-1:0] s2_raw;
  logic [PROD_W-1:0] s2_prod;

  adc_corr_coef_sel #(
    .DATA_W(DATA_W), .GAIN_MAG_W(GAIN_MAG_W), .GAIN_DEN(GAIN_DEN)
  ) u_coef_sel (
    .sel_i      (in_sel_i),
    .off_word_i (off_words),
    .gain_code_i(gain_codes),
    .off_word_o (off_sel),
    .factor_o   (fact_sel)
  );

  adc_corr_offset_stg #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FACT_W(FACT_W)
  ) u_offset_stg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (in_valid_i),
    .cal_en_i  (cal_en_i),
    .raw_i     (in_data_i),
    .off_word_i(off_sel),
    .factor_i  (fact_sel),
    .valid_o   (s1_valid),
    .byp_o     (s1_byp),
    .raw_o     (s1_raw),
    .sum_o     (s1_sum),
    .factor_o  (s1_fact)
  );

  adc_corr_gain_stg #(
    .DATA_W(DATA_W), .FACT_W(FACT_W)
  ) u_gain_stg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .byp_i   (s1_byp),
    .raw_i   (s1_raw),
    .sum_i   (s1_sum),
    .factor_i(s1_fact),
    .valid_o (s2_valid),
    .byp_o   (s2_byp),
    .raw_o   (s2_raw),
    .prod_o  (s2_prod)
  );

  adc_corr_norm_stg #(
    .DATA_W(DATA_W), .PROD_W(PROD_W), .GAIN_DEN(GAIN_DEN)
  ) u_norm_stg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s2_valid),
    .byp_i  (s2_byp),
    .raw_i  (s2_raw),
    .prod_i (s2_prod),
    .valid_o(out_valid_o),
    .data_o (out_data_o)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##3 out_valid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##3 !out_valid_o); // R2
  AST_BYPASS_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !cal_en_i) |-> ##3 (out_data_o == $past(in_data_i, 3))); // R3
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && out_data_o == '0)); // R1
endmodule

// File: tb/adc_corr_top_tb.sv
module adc_corr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_sel = 2'd0;
  logic [15:0] in_data = 16'd0;
  logic [15:0] off_a = 16'd0, off_b = 16'd0, off_sa = 16'd0, off_sb = 16'd0;
  logic [6:0]  gain_a = 7'd0, gain_b = 7'd0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R2";

  always #5 clk = ~clk;

  adc_corr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cal_en_i(cal_en), .in_valid_i(in_valid),
    .in_sel_i(in_sel), .in_data_i(in_data),
    .off_adc_a_i(off_a), .off_adc_b_i(off_b), .off_sup_a_i(off_sa), .off_sup_b_i(off_sb),
    .gain_a_i(gain_a), .gain_b_i(gain_b),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  function automatic int model(input logic [15:0] d, input logic [1:0] s, input logic en);
    logic [15:0] ow;
    logic [6:0]  gc;
    longint sum, fct, q;
    if (!en) return int'(d);
    case (s)
      2'd0: ow = off_a;
      2'd1: ow = off_b;
      2'd2: ow = off_sa;
      default: ow = off_sb;
    endcase
    gc  = s[0] ? gain_b : gain_a;
    sum = longint'(d) + longint'($signed(ow[15:4])) * 16;
    fct = gc[6] ? 1000 + longint'(gc[5:0]) : 1000 - longint'(gc[5:0]);
    if (sum <= 0) return 0;
    q = (sum * fct + 500) / 1000;
    return (q > 65535) ? 65535 : int'(q);
  endfunction

  // reference pipeline: slot 2 is what the outputs show after the edge
  bit    m_v [3];
  int    m_d [3];
  string m_t [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_v[i] = 1'b0; m_d[i] = 0; m_t[i] = "R1"; end
    end else begin
      m_v[2] = m_v[1]; m_d[2] = m_d[1]; m_t[2] = m_t[1];
      m_v[1] = m_v[0]; m_d[1] = m_d[0]; m_t[1] = m_t[0];
      m_v[0] = in_valid;
      m_d[0] = in_valid ? model(in_data, in_sel, cal_en) : 0;
      m_t[0] = cur_tag;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_valid !== m_v[2]) begin
        errors++;
        $display("FAIL R2 valid: actual %0b expected %0b", out_valid, m_v[2]);
      end else if (m_v[2]) begin
        checks++;
        if (int'(out_data) != m_d[2]) begin
          errors++;
          $display("FAIL %s data: actual %04h expected %04h", m_t[2], out_data, m_d[2][15:0]);
        end
      end
    end
  end

  task automatic send(input logic [15:0] d, input logic [1:0] s, input logic en, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sel = s; cal_en = en; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_data = 16'hdead;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset: actual %0b/%04h expected 0/0000", out_valid, out_data);
    end
    rst_n = 1'b1;
    // R3 bypass with nonzero coefficients
    off_a = 16'h7ff0; gain_a = 7'h7f; off_b = 16'h8000; gain_b = 7'h3f;
    send(16'h1234, 2'd0, 1'b0, "R3");
    send(16'hffff, 2'd1, 1'b0, "R3");
    send(16'h0000, 2'd2, 1'b0, "R3");
    idle(2);
    // R6 identity and rounding, gaps between samples (R2)
    off_a = 16'h0; gain_a = 7'h00;
    send(16'habcd, 2'd0, 1'b1, "R6");
    idle(1);
    gain_a = 7'h41;
    send(16'd500, 2'd0, 1'b1, "R6");   // 500.5 rounds up to 501
    send(16'd1500, 2'd0, 1'b1, "R6");  // 1501.5 -> 1502
    idle(3);
    // R4 offset: -10 LSB error word with garbage low nibble
    gain_a = 7'h00; off_a = 16'hff6a;
    send(16'h8000, 2'd0, 1'b1, "R4");
    off_a = 16'h00af;                    // +10, nibble ignored
    send(16'h8000, 2'd0, 1'b1, "R4");
    // R5 gain both signs and the -1% code
    off_a = 16'h0;
    gain_a = 7'b000_1010; send(16'd40000, 2'd0, 1'b1, "R5");
    gain_a = 7'h7f;       send(16'd40000, 2'd0, 1'b1, "R5");
    gain_a = 7'h3f;       send(16'd40000, 2'd0, 1'b1, "R5");
    // R7 / R8 saturation
    off_a = 16'h7ff0; gain_a = 7'h7f;
    send(16'hfff0, 2'd0, 1'b1, "R7");
    gain_a = 7'h00; off_a = 16'h0010;
    send(16'hfff0, 2'd0, 1'b1, "R7");   // exactly 65536 -> FFFF
    off_a = 16'hff60;
    send(16'h0010, 2'd0, 1'b1, "R8");
    send(16'h00a0, 2'd0, 1'b1, "R8");   // exactly zero
    // R9 source selection with distinct coefficient sets
    off_a = 16'h0100; off_b = 16'h0200; off_sa = 16'hff00; off_sb = 16'h0400;
    gain_a = 7'h45; gain_b = 7'h05;
    for (int s = 0; s < 4; s++) send(16'h4000, 2'(s), 1'b1, "R9");
    idle(4);
    // randomized back-to-back burst with coefficient churn
    for (int i = 0; i < 600; i++) begin
      if (i % 37 == 0) begin
        off_a = 16'($urandom); off_b = 16'($urandom);
        off_sa = 16'($urandom); off_sb = 16'($urandom);
        gain_a = 7'($urandom); gain_b = 7'($urandom);
      end
      if ($urandom % 5 == 0) idle(1);
      else send(16'($urandom), 2'($urandom), ($urandom % 6) != 0, "R6");
    end
    idle(6);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule